// File: doc/BRIEF.md
# Byte-Code Instruction Sequencer

This block is a small multi-cycle processor front end that runs a narrow subset of a classic 8-bit microcontroller instruction set. It fetches one opcode byte from an external byte-wide program memory, decodes from that byte how many operand bytes follow and what kind of operand each one is, fetches those bytes, and then executes the instruction in a single execute cycle. It keeps a 16-bit program counter, an 8-bit accumulator, an 8-bit stack pointer, and a 128-byte internal data RAM. The first eight RAM bytes serve as working registers 0 to 7.

The program memory is synchronous. The block drives an address, and the memory returns that byte on the following clock edge. Each time an instruction completes, the block gives a one-cycle completion pulse. With that pulse it updates the program counter, the accumulator, the class of the instruction just finished, and a flag that marks an unrecognised opcode. A system uses the block by connecting a program memory to it and watching the completion pulse.

Top module: `tiny_seq`

## Requirements
- R1: After reset the program counter is 0x0000, the accumulator is 0x00, the completion pulse and the illegal flag are low, the class output is 0 (no-op), all data RAM bytes are 0x00, and the stack pointer is 0x07.
- R2: The opcode is read at PC, the first operand at PC+1 and the second operand at PC+2. Lengths are as follows: 0x00 takes 1 byte; 0x74, 0xE5, 0xC0, 0xD0 and 0xD2 take 2; 0x75 takes 3; 0xE6 to 0xEF take 1; every other value takes 1. Except for the jump, a completed instruction leaves PC equal to the old PC plus its length, modulo 2^16.
- R3: Opcode 0xD2 is a relative jump. The new PC is the old PC plus 2 plus the sign-extended operand byte, modulo 2^16, so it can wrap in either direction.
- R4: Opcode 0x74 loads the operand byte into the accumulator. Opcode 0xE5 loads the RAM byte at the operand address. For every direct address only the low 7 bits select the RAM byte.
- R5: Opcode 0x75 writes its second operand byte into RAM at the address held in its first operand byte. The accumulator does not change.
- R6: Opcodes 0xE8 to 0xEF load RAM byte 0 to 7, selected by the low 3 opcode bits, into the accumulator. Opcodes 0xE6 and 0xE7 load the RAM byte whose address is the low 7 bits of RAM byte 0 or RAM byte 1, respectively.
- R7: Opcode 0xC0 first increments the stack pointer and then copies the RAM byte at the direct operand to RAM at the new stack pointer. Opcode 0xD0 copies the RAM byte at the stack pointer to the direct operand address and then decrements the stack pointer.
- R8: An unlisted opcode is treated as 1 byte long. It raises the illegal flag with its completion pulse and changes neither the accumulator nor the RAM. Instructions other than the MOV forms leave the accumulator unchanged.
- R9: The completion pulse lasts exactly one cycle per instruction. Successive pulses are (length + 2) cycles apart. With each pulse the class output shows the completed instruction as 0 no-op, 1 move, 2 push, 3 pop, 4 jump or 5 illegal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| pmem_addr_o | output | 16 | Program memory byte address |
| pmem_data_i | input | 8 | Program memory byte, returned one cycle after its address |
| pc_o | output | 16 | Program counter |
| acc_o | output | 8 | Accumulator |
| op_class_o | output | 3 | Class of the last completed instruction |
| illegal_o | output | 1 | Last completed opcode was unrecognised |
| step_done_o | output | 1 | One-cycle pulse per completed instruction |

## Verification
The program used for the test begins with a backward jump from address 0 that wraps to 0xFFFE. A forward jump placed there wraps back past zero. Together these show whether the offset is taken from the advanced PC with 16-bit wrap. The program then uses every MOV addressing form on data that earlier stores placed in RAM. Register and indirect reads fetch different values, so a wrong index or a missing level of indirection shows up. Two pushes followed by two pops into fresh addresses tell pre-increment from post-increment. A later direct read of byte 0x08 shows the reset stack pointer. A read through address 0xB0 shows that the top address bit is ignored. An illegal byte in the middle of the program checks its length and that it has no side effects. Each completed step is compared with a bench model for PC, accumulator, class and the spacing between completion pulses.

// File: rtl/tseq_pkg.sv
package tseq_pkg;

  localparam int PC_W = 16;
  localparam int DW   = 8;

  typedef enum logic [2:0] {
    CLS_NOP  = 3'd0,
    CLS_MOV  = 3'd1,
    CLS_PUSH = 3'd2,
    CLS_POP  = 3'd3,
    CLS_JUMP = 3'd4,
    CLS_ILL  = 3'd5
  } op_cls_e;

  // where a MOV takes its value from (or STORE: immediate into RAM)
  typedef enum logic [2:0] {
    SRC_NONE, SRC_IMM, SRC_DIR, SRC_REG, SRC_IND, SRC_STORE
  } src_e;

  typedef enum logic [2:0] {
    ST_OP, ST_DEC, ST_B1, ST_B2, ST_EXE
  } st_e;

  typedef struct packed {
    op_cls_e    cls;
    src_e       src;
    logic [1:0] len;
    logic [2:0] ridx;
  } dec_t;

  function automatic dec_t decode_op(input logic [DW-1:0] op);
    dec_t d;
    d.cls  = CLS_ILL;
    d.src  = SRC_NONE;
    d.len  = 2'd1;
    d.ridx = op[2:0];
    if (op == 8'h00) begin
      d.cls = CLS_NOP;
    end else if (op == 8'h74) begin
      d.cls = CLS_MOV; d.src = SRC_IMM; d.len = 2'd2;
    end else if (op == 8'hE5) begin
      d.cls = CLS_MOV; d.src = SRC_DIR; d.len = 2'd2;
    end else if (op == 8'h75) begin
      d.cls = CLS_MOV; d.src = SRC_STORE; d.len = 2'd3;
    end else if (op[7:1] == 7'b1110_011) begin
      d.cls = CLS_MOV; d.src = SRC_IND; d.ridx = {2'b00, op[0]};
    end else if (op[7:3] == 5'b11101) begin
      d.cls = CLS_MOV; d.src = SRC_REG;
    end else if (op == 8'hC0) begin
      d.cls = CLS_PUSH; d.len = 2'd2;
    end else if (op == 8'hD0) begin
      d.cls = CLS_POP; d.len = 2'd2;
    end else if (op == 8'hD2) begin
      d.cls = CLS_JUMP; d.len = 2'd2;
    end
    return d;
  endfunction

  // PC after completion: advance by length, then add signed offset for a jump
  function automatic logic [PC_W-1:0] step_pc(input logic [PC_W-1:0] pc,
                                               input logic [1:0]      len,
                                               input logic            jump,
                                               input logic [DW-1:0]   off);
    logic [PC_W-1:0] adv;
    adv = pc + PC_W'(len);
    if (jump) adv = adv + {{(PC_W-DW){off[DW-1]}}, off};
    return adv;
  endfunction

endpackage

// File: rtl/tseq_dec.sv
module tseq_dec
  import tseq_pkg::*;
(
  input  logic [DW-1:0] op_i,
  output dec_t          dec_o
);

  assign dec_o = decode_op(op_i);

endmodule

// File: rtl/tseq_dram.sv
module tseq_dram #(
  parameter int DEPTH = 128,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic [AW-1:0] raddr_a_i,
  output logic [7:0]    rdata_a_o,
  input  logic [AW-1:0] raddr_b_i,
  output logic [7:0]    rdata_b_o
);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
    end else if (we_i) begin
      mem[waddr_i] <= wdata_i;
    end
  end

  assign rdata_a_o = mem[raddr_a_i];
  assign rdata_b_o = mem[raddr_b_i];

endmodule

// File: rtl/tseq_ctrl.sv
module tseq_ctrl
  import tseq_pkg::*;
#(
  parameter int          DEPTH   = 128,
  parameter logic [7:0]  SP_INIT = 8'h07,
  localparam int         AW      = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [PC_W-1:0] prog_addr_o,
  input  logic [DW-1:0]   prog_data_i,
  output logic [DW-1:0]   dec_op_o,
  input  dec_t            dec_i,
  output logic            wr_en_o,
  output logic [AW-1:0]   wr_addr_o,
  output logic [7:0]      wr_data_o,
  output logic [AW-1:0]   rd_a_addr_o,
  input  logic [7:0]      rd_a_data_i,
  output logic [AW-1:0]   rd_b_addr_o,
  input  logic [7:0]      rd_b_data_i,
  output logic [PC_W-1:0] pc_o,
  output logic [DW-1:0]   acc_o,
  output logic [2:0]      cls_o,
  output logic            ill_o,
  output logic            done_o
);

  st_e             state_q, state_d;
  logic [PC_W-1:0] pc_q;
  logic [DW-1:0]   acc_q, opc_q, b1_q, b2_q;
  logic [7:0]      sp_q;
  op_cls_e         cls_q;
  logic            ill_q, done_q;

  // named internal events
  logic            exe_now;
  logic            acc_load;
  logic [DW-1:0]   acc_val;
  logic [7:0]      sp_next;
  logic [PC_W-1:0] pc_new;

  assign exe_now  = (state_q == ST_EXE);
  assign dec_op_o = (state_q == ST_DEC) ? prog_data_i : opc_q;

  always_comb begin
    case (state_q)
      ST_DEC:  prog_addr_o = pc_q + PC_W'(1);
      ST_B1:   prog_addr_o = pc_q + PC_W'(2);
      default: prog_addr_o = pc_q;
    endcase
  end

  always_comb begin
    case (state_q)
      ST_OP:   state_d = ST_DEC;
      ST_DEC:  state_d = (dec_i.len == 2'd1) ? ST_EXE : ST_B1;
      ST_B1:   state_d = (dec_i.len == 2'd3) ? ST_B2 : ST_EXE;
      ST_B2:   state_d = ST_EXE;
      default: state_d = ST_OP;
    endcase
  end

  // RAM read addressing
  always_comb begin
    if (dec_i.cls == CLS_POP)
      rd_a_addr_o = sp_q[AW-1:0];
    else if (dec_i.cls == CLS_MOV && (dec_i.src == SRC_REG || dec_i.src == SRC_IND))
      rd_a_addr_o = AW'(dec_i.ridx);
    else
      rd_a_addr_o = b1_q[AW-1:0];
  end
  assign rd_b_addr_o = rd_a_data_i[AW-1:0];

  always_comb begin
    case (dec_i.src)
      SRC_DIR, SRC_REG: acc_val = rd_a_data_i;
      SRC_IND:          acc_val = rd_b_data_i;
      default:          acc_val = b1_q;
    endcase
  end
  assign acc_load = exe_now && dec_i.cls == CLS_MOV && dec_i.src != SRC_STORE;

  always_comb begin
    wr_en_o   = 1'b0;
    wr_addr_o = b1_q[AW-1:0];
    wr_data_o = rd_a_data_i;
    sp_next   = sp_q;
    if (exe_now) begin
      case (dec_i.cls)
        CLS_MOV: if (dec_i.src == SRC_STORE) begin
          wr_en_o   = 1'b1;
          wr_data_o = b2_q;
        end
        CLS_PUSH: begin
          sp_next   = sp_q + 8'd1;
          wr_en_o   = 1'b1;
          wr_addr_o = sp_next[AW-1:0];
        end
        CLS_POP: begin
          sp_next   = sp_q - 8'd1;
          wr_en_o   = 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign pc_new = step_pc(pc_q, dec_i.len, dec_i.cls == CLS_JUMP, b1_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_OP;
      pc_q    <= '0;
      acc_q   <= '0;
      opc_q   <= '0;
      b1_q    <= '0;
      b2_q    <= '0;
      sp_q    <= SP_INIT;
      cls_q   <= CLS_NOP;
      ill_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= exe_now;
      if (state_q == ST_DEC) opc_q <= prog_data_i;
      if (state_q == ST_B1)  b1_q  <= prog_data_i;
      if (state_q == ST_B2)  b2_q  <= prog_data_i;
      if (acc_load)          acc_q <= acc_val;
      if (exe_now) begin
        pc_q  <= pc_new;
        sp_q  <= sp_next;
        cls_q <= dec_i.cls;
        ill_q <= (dec_i.cls == CLS_ILL);
      end
    end
  end

  assign pc_o   = pc_q;
  assign acc_o  = acc_q;
  assign cls_o  = cls_q;
  assign ill_o  = ill_q;
  assign done_o = done_q;

  // completion pulse lasts one cycle
  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // PC moves only with a completion
  p_pc_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !done_q |-> $stable(pc_q));

  // an unknown opcode advances PC by exactly one
  p_illegal_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && ill_q) |-> (pc_q == PC_W'($past(pc_q) + PC_W'(1))));

  // stack pointer steps by one per push or pop
  p_sp_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && cls_q == CLS_PUSH) |-> (sp_q == 8'($past(sp_q) + 8'd1)));
  p_sp_pop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && cls_q == CLS_POP) |-> (sp_q == 8'($past(sp_q) - 8'd1)));

  // only moves touch the accumulator
  p_acc_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && cls_q != CLS_MOV) |-> (acc_q == $past(acc_q)));

endmodule

// File: rtl/tiny_seq.sv
module tiny_seq
  import tseq_pkg::*;
#(
  parameter int         RAM_DEPTH = 128,
  parameter logic [7:0] SP_INIT   = 8'h07
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [15:0]  pmem_addr_o,
  input  logic [7:0]   pmem_data_i,
  output logic [15:0]  pc_o,
  output logic [7:0]   acc_o,
  output logic [2:0]   op_class_o,
  output logic         illegal_o,
  output logic         step_done_o
);

  localparam int AW = $clog2(RAM_DEPTH);

  logic [DW-1:0] dec_op;
  dec_t          dec;
  logic          we;
  logic [AW-1:0] waddr, raddr_a, raddr_b;
  logic [7:0]    wdata, rdata_a, rdata_b;

  tseq_dec u_dec (
    .op_i  (dec_op),
    .dec_o (dec)
  );

  tseq_dram #(.DEPTH(RAM_DEPTH)) u_ram (
    .clk       (clk),
    .rst_n     (rst_n),
    .we_i      (we),
    .waddr_i   (waddr),
    .wdata_i   (wdata),
    .raddr_a_i (raddr_a),
    .rdata_a_o (rdata_a),
    .raddr_b_i (raddr_b),
    .rdata_b_o (rdata_b)
  );

  tseq_ctrl #(.DEPTH(RAM_DEPTH), .SP_INIT(SP_INIT)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .prog_addr_o (pmem_addr_o),
    .prog_data_i (pmem_data_i),
    .dec_op_o    (dec_op),
    .dec_i       (dec),
    .wr_en_o     (we),
    .wr_addr_o   (waddr),
    .wr_data_o   (wdata),
    .rd_a_addr_o (raddr_a),
    .rd_a_data_i (rdata_a),
    .rd_b_addr_o (raddr_b),
    .rd_b_data_i (rdata_b),
    .pc_o        (pc_o),
    .acc_o       (acc_o),
    .cls_o       (op_class_o),
    .ill_o       (illegal_o),
    .done_o      (step_done_o)
  );

endmodule

// File: tb/tiny_seq_bench.sv
module tiny_seq_bench;

  localparam int CLK_PERIOD = 10;
  localparam int N_STEPS    = 31;
  localparam int WD_LIMIT   = 5000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] pmem_addr;
  logic [7:0]  pmem_data = 8'h00;
  logic [15:0] pc;
  logic [7:0]  acc;
  logic [2:0]  op_class;
  logic        illegal;
  logic        step_done;

  tiny_seq u_tiny_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .pmem_addr_o (pmem_addr),
    .pmem_data_i (pmem_data),
    .pc_o        (pc),
    .acc_o       (acc),
    .op_class_o  (op_class),
    .illegal_o   (illegal),
    .step_done_o (step_done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // 256-byte image mirrored across the whole 16-bit space
  logic [7:0] img [256];
  always @(posedge clk) pmem_data <= img[pmem_addr[7:0]];

  typedef struct {
    logic [15:0] pc;
    logic [7:0]  acc;
    logic [2:0]  cls;
    logic        ill;
    int          gap;
    string       tag;
  } item_t;

  item_t exp_q[$];
  int checks = 0;
  int errors = 0;

  // bench reference state
  logic [15:0] m_pc;
  logic [7:0]  m_acc;
  logic [7:0]  m_sp;
  logic [7:0]  m_ram [128];

  task automatic chk(string tag, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic put(int a, logic [7:0] b);
    img[a[7:0]] = b;
  endtask

  // driver: work out one instruction from the requirements and queue it
  task automatic drive_step();
    item_t it;
    logic [7:0] op, b1, b2;
    int len;
    op = img[m_pc[7:0]];
    b1 = img[8'(m_pc[7:0] + 8'd1)];
    b2 = img[8'(m_pc[7:0] + 8'd2)];
    len = 1; it.cls = 3'd5; it.ill = 1'b0; it.tag = "R2";
    case (op) inside
      8'h00: begin it.cls = 3'd0; end
      8'h74: begin len = 2; it.cls = 3'd1; m_acc = b1; it.tag = "R4"; end
      8'hE5: begin len = 2; it.cls = 3'd1; m_acc = m_ram[b1 & 8'h7F]; it.tag = "R4 R1"; end
      8'h75: begin len = 3; it.cls = 3'd1; m_ram[b2 == b2 ? (b1 & 8'h7F) : 0] = b2; it.tag = "R5"; end
      8'hE6, 8'hE7: begin it.cls = 3'd1; m_acc = m_ram[m_ram[op & 8'h01] & 8'h7F]; it.tag = "R6"; end
      [8'hE8:8'hEF]: begin it.cls = 3'd1; m_acc = m_ram[op - 8'hE8]; it.tag = "R6"; end
      8'hC0: begin len = 2; it.cls = 3'd2; m_sp = m_sp + 8'd1; m_ram[m_sp & 8'h7F] = m_ram[b1 & 8'h7F]; it.tag = "R7"; end
      8'hD0: begin len = 2; it.cls = 3'd3; m_ram[b1 & 8'h7F] = m_ram[m_sp & 8'h7F]; m_sp = m_sp - 8'd1; it.tag = "R7"; end
      8'hD2: begin len = 2; it.cls = 3'd4; it.tag = "R3"; end
      default: begin it.ill = 1'b1; it.tag = "R8"; end
    endcase
    if (op == 8'hD2) m_pc = 16'(m_pc + 16'(len) + {{8{b1[7]}}, b1});
    else             m_pc = 16'(m_pc + 16'(len));
    it.pc  = m_pc;
    it.acc = m_acc;
    it.gap = len + 2;
    exp_q.push_back(it);
  endtask

  initial begin
    item_t got;
    int ncyc, last_cyc, nseen;
    for (int i = 0; i < 256; i++) img[i] = 8'h00;
    for (int i = 0; i < 128; i++) m_ram[i] = 8'h00;
    m_pc = 16'h0000; m_acc = 8'h00; m_sp = 8'h07;

    // program
    put(8'h00, 8'hD2); put(8'h01, 8'hFC);                 // jump back, wraps to 0xFFFE
    put(8'hFE, 8'hD2); put(8'hFF, 8'h04);                 // wraps forward to 0x0004
    put(8'h04, 8'h00);                                    // no-op
    put(8'h05, 8'h74); put(8'h06, 8'h5A);                 // A = 5A
    put(8'h07, 8'h75); put(8'h08, 8'h03); put(8'h09, 8'hC3); // reg3 = C3
    put(8'h0A, 8'hEB);                                    // A = reg3
    put(8'h0B, 8'h75); put(8'h0C, 8'h01); put(8'h0D, 8'h20); // reg1 = 20
    put(8'h0E, 8'h75); put(8'h0F, 8'h20); put(8'h10, 8'h77); // [20] = 77
    put(8'h11, 8'hE7);                                    // A = [reg1]
    put(8'h12, 8'h75); put(8'h13, 8'h00); put(8'h14, 8'h21); // reg0 = 21
    put(8'h15, 8'h75); put(8'h16, 8'h21); put(8'h17, 8'h11); // [21] = 11
    put(8'h18, 8'hE6);                                    // A = [reg0]
    put(8'h19, 8'hA5);                                    // illegal
    put(8'h1A, 8'hC0); put(8'h1B, 8'h20);                 // push [20]
    put(8'h1C, 8'hC0); put(8'h1D, 8'h03);                 // push reg3
    put(8'h1E, 8'hD0); put(8'h1F, 8'h30);                 // pop to 30
    put(8'h20, 8'hD0); put(8'h21, 8'h31);                 // pop to 31
    put(8'h22, 8'hE5); put(8'h23, 8'h30);
    put(8'h24, 8'hE5); put(8'h25, 8'h31);
    put(8'h26, 8'hE5); put(8'h27, 8'hB0);                 // top address bit ignored
    put(8'h28, 8'hE5); put(8'h29, 8'h08);                 // first push slot
    put(8'h2A, 8'hE8); put(8'h2B, 8'hE9); put(8'h2C, 8'hEF);
    put(8'h2D, 8'h74); put(8'h2E, 8'h80);
    put(8'h2F, 8'hD2); put(8'h30, 8'h02);                 // forward jump to 0x33
    put(8'h33, 8'hD2); put(8'h34, 8'hFE);                 // jump to itself

    for (int s = 0; s < N_STEPS; s++) drive_step();

    // reset state (R1)
    repeat (3) @(negedge clk);
    chk("R1", pc, 16'h0000, "pc");
    chk("R1", acc, 8'h00, "acc");
    chk("R1", step_done, 0, "step_done");
    chk("R1", illegal, 0, "illegal");
    chk("R1", op_class, 0, "class");
    rst_n = 1'b1;

    ncyc = 0; last_cyc = -1; nseen = 0;
    fork
      begin : monitor
        forever begin
          @(negedge clk);
          ncyc++;
          if (step_done) begin
            if (exp_q.size() == 0) begin
              chk("R9", 1, 0, "unexpected completion");
            end else begin
              got = exp_q.pop_front();
              chk(got.tag, pc, got.pc, "pc");
              chk(got.tag, acc, got.acc, "acc");
              chk((got.ill ? "R8" : "R9"), op_class, got.cls, "class");
              chk("R8", illegal, got.ill, "illegal flag");
              if (last_cyc >= 0) chk("R9", ncyc - last_cyc, got.gap, "pulse spacing");
              last_cyc = ncyc;
              nseen++;
            end
          end
        end
      end
      begin : watchdog
        for (int c = 0; c < WD_LIMIT && exp_q.size() != 0; c++) @(posedge clk);
        if (exp_q.size() != 0) chk("R9", exp_q.size(), 0, "watchdog: steps left");
        @(negedge clk);
        @(negedge clk);
      end
    join_any
    disable fork;

    chk("R9", nseen, N_STEPS, "completed steps");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule